// File: doc/BRIEF.md
# Multi-Sensor Pulse-Count Temperature Reader

This block runs measurements on up to three two-wire temperature sensors that share one data return line. Each sensor stays unpowered between readings. When powered, it first spends some tens of milliseconds converting. It then sends its reading as a burst of pulses, and the number of pulses encodes the temperature.

A requester raises a one-cycle start together with a sensor index. For a valid index, the block switches on that sensor's power output and clears the previous result. It then opens a one-shot count window that is a fixed number of 1 ms ticks long. The window is set well beyond the sensor's conversion time so that the whole pulse burst falls inside it.

Falling edges on the shared data line are synchronized and counted. When the window closes, power is removed, the count is latched and ready is raised. A zero count flags a dead or missing sensor. An index outside 1 to 3 is refused with an error output, and nothing is powered.

Top module: `pulse_temp_reader`

## Requirements
- R1: After reset, every power output, busy, ready, fault and index error is low and the result is zero.
- R2: While a measurement runs, exactly one power output is high: bit index-1 for index 1, 2 or 3. No other power bit rises.
- R3: A start with index 0 or an index above 3 raises the index error output on the next cycle. Busy stays low, ready stays low and no power bit rises.
- R4: A start accepted while idle clears the result, ready, fault and index error on the next cycle.
- R5: Each falling edge of the data line during a measurement adds exactly one to the pulse count.
- R6: The window is one-shot. Busy is high for exactly TICK_DIV*WIN_TICKS clock cycles counted from the start edge. Power drops on the same edge on which ready rises.
- R7: When the window expires, the count is copied to the result and ready is set. Both hold until the next accepted start.
- R8: A latched count of zero sets the fault output. A nonzero count leaves it low.
- R9: The 13-bit count saturates at 8191 and does not wrap.
- R10: A start request while busy is ignored. The powered sensor and the window end are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle measurement request |
| sel_i | input | SEL_W | Sensor index, 1..NUM_SENSORS valid |
| sens_data_i | input | 1 | Shared sensor pulse line (asynchronous) |
| pwr_o | output | NUM_SENSORS | Per-sensor power enables |
| busy_o | output | 1 | Measurement window open |
| ready_o | output | 1 | Result valid |
| count_o | output | CNT_W | Latched pulse count |
| fault_o | output | 1 | Latched count was zero |
| idx_err_o | output | 1 | Last start had an invalid index |

## Verification
The hardest condition to reach is counter saturation. The count only climbs by one per observed falling edge, and 8191 edges must arrive inside one window. The bench therefore shortens the tick to 200 clocks and drives the data line with a dense two-cycle square wave of 8300 periods. That pushes the counter past its ceiling while the window is still open. A second case that takes deliberate timing is a start arriving mid-window. The bench places it between pulse bursts and then times the window from the first start.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_MEAS = 1'b1
  } ptr_state_e;
endpackage

// File: rtl/ptr_fall_detect.sv
module ptr_fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic din_i,
  output logic fall_o
);
  // two synchronizer stages plus one history stage; idle level is high
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= din_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign fall_o = s3_q & ~s2_q;

  a_r5_single_cycle_edge: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/ptr_window_timer.sv
module ptr_window_timer #(
  parameter int TICK_DIV  = 100000,
  parameter int WIN_TICKS = 104
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic running_o,
  output logic expire_o
);
  localparam int PW = (TICK_DIV  > 1) ? $clog2(TICK_DIV)  : 1;
  localparam int TW = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1;

  logic          run_q, run_d;
  logic [PW-1:0] pre_q, pre_d;
  logic [TW-1:0] tck_q, tck_d;
  logic          tick;

  assign tick     = run_q && (pre_q == PW'(TICK_DIV - 1));
  assign expire_o = tick && (tck_q == TW'(WIN_TICKS - 1));
  assign running_o = run_q;

  always_comb begin
    run_d = run_q;
    pre_d = pre_q;
    tck_d = tck_q;
    if (start_i) begin
      run_d = 1'b1;
      pre_d = '0;
      tck_d = '0;
    end else if (run_q) begin
      if (tick) begin
        pre_d = '0;
        tck_d = tck_q + 1'b1;
        if (expire_o) begin
          run_d = 1'b0;
          tck_d = '0;
        end
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      pre_q <= '0;
      tck_q <= '0;
    end else begin
      run_q <= run_d;
      pre_q <= pre_d;
      tck_q <= tck_d;
    end
  end

  a_r6_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !start_i) |=> !run_q);
  a_r6_no_expire_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !expire_o);
endmodule

// File: rtl/ptr_sat_counter.sv
module ptr_sat_counter #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CMAX = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                        cnt_d = '0;
    else if (inc_i && cnt_q != CMAX)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && cnt_q == CMAX) |=> cnt_q == CMAX);
  a_r5_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/pulse_temp_reader.sv
module pulse_temp_reader
  import ptr_pkg::*;
#(
  parameter int NUM_SENSORS = 3,
  parameter int SEL_W       = 3,
  parameter int CNT_W       = 13,
  parameter int TICK_DIV    = 100000,
  parameter int WIN_TICKS   = 104
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [SEL_W-1:0]       sel_i,
  input  logic                   sens_data_i,
  output logic [NUM_SENSORS-1:0] pwr_o,
  output logic                   busy_o,
  output logic                   ready_o,
  output logic [CNT_W-1:0]       count_o,
  output logic                   fault_o,
  output logic                   idx_err_o
);
  ptr_state_e             st_q, st_d;
  logic [NUM_SENSORS-1:0] pwr_q, pwr_d, sel_dec;
  logic                   rdy_q, rdy_d, flt_q, flt_d, err_q, err_d;
  logic [CNT_W-1:0]       res_q, res_d, cnt;
  logic                   fall, expire, running;
  logic                   accept, sel_ok, go;

  // index decode: sensor n sits on power bit n-1
  for (genvar g = 0; g < NUM_SENSORS; g++) begin : g_dec
    assign sel_dec[g] = (sel_i == SEL_W'(g + 1));
  end
  assign sel_ok = |sel_dec;
  assign accept = start_i && (st_q == ST_IDLE);
  assign go     = accept && sel_ok;

  ptr_fall_detect u_edge (
    .clk(clk), .rst_n(rst_n), .din_i(sens_data_i), .fall_o(fall)
  );

  ptr_window_timer #(.TICK_DIV(TICK_DIV), .WIN_TICKS(WIN_TICKS)) u_win (
    .clk(clk), .rst_n(rst_n), .start_i(go), .running_o(running), .expire_o(expire)
  );

  ptr_sat_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(go),
    .inc_i(fall && st_q == ST_MEAS), .cnt_o(cnt)
  );

  always_comb begin
    st_d  = st_q;
    pwr_d = pwr_q;
    rdy_d = rdy_q;
    flt_d = flt_q;
    err_d = err_q;
    res_d = res_q;
    if (accept) begin
      res_d = '0;
      rdy_d = 1'b0;
      flt_d = 1'b0;
      err_d = !sel_ok;
      if (sel_ok) begin
        st_d  = ST_MEAS;
        pwr_d = sel_dec;
      end
    end else if (st_q == ST_MEAS && expire) begin
      st_d  = ST_IDLE;
      pwr_d = '0;
      res_d = cnt;
      rdy_d = 1'b1;
      flt_d = (cnt == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      pwr_q <= '0;
      rdy_q <= 1'b0;
      flt_q <= 1'b0;
      err_q <= 1'b0;
      res_q <= '0;
    end else begin
      st_q  <= st_d;
      pwr_q <= pwr_d;
      rdy_q <= rdy_d;
      flt_q <= flt_d;
      err_q <= err_d;
      res_q <= res_d;
    end
  end

  assign pwr_o     = pwr_q;
  assign busy_o    = (st_q == ST_MEAS);
  assign ready_o   = rdy_q;
  assign count_o   = res_q;
  assign fault_o   = flt_q;
  assign idx_err_o = err_q;

  a_r2_one_powered: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> ($countones(pwr_o) == 1));
  a_r2_idle_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (pwr_o == '0));
  a_r6_power_off_at_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> (pwr_o == '0 && !running));
  a_r10_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !expire) |=> ($stable(pwr_o) && busy_o));
  a_r8_fault_matches: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (fault_o == (count_o == '0)));
  a_r3_error_idle: assert property (@(posedge clk) disable iff (!rst_n)
    idx_err_o |-> (!busy_o && !ready_o));
endmodule

// File: tb/sim_pulse_temp_reader.sv
`timescale 1ns/1ps
module sim_pulse_temp_reader;
  localparam int NS = 3, SW = 3, CW = 13, TD = 200, WT = 104;
  localparam int WIN = TD * WT;

  logic clk, rst_n, start, data;
  logic [SW-1:0] sel;
  logic [NS-1:0] pwr;
  logic busy, ready, fault, ierr;
  logic [CW-1:0] cnt;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  pulse_temp_reader #(.NUM_SENSORS(NS), .SEL_W(SW), .CNT_W(CW),
                      .TICK_DIV(TD), .WIN_TICKS(WT)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .sel_i(sel), .sens_data_i(data),
    .pwr_o(pwr), .busy_o(busy), .ready_o(ready), .count_o(cnt),
    .fault_o(fault), .idx_err_o(ierr));

  initial clk = 0;
  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    wait (cyc >= 190000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  task automatic do_start(input int s);
    @(negedge clk);
    start = 1; sel = SW'(s);
    @(negedge clk);
    start = 0; sel = '0;
  endtask

  task automatic pulses(input int n, input int half);
    for (int i = 0; i < n; i++) begin
      data = 0; repeat (half) @(negedge clk);
      data = 1; repeat (half) @(negedge clk);
    end
  endtask

  // returns cycles from start edge to the edge raising ready
  task automatic wait_ready(input int t0, output int dur);
    while (!ready && cyc < t0 + WIN + 50) @(negedge clk);
    dur = cyc - t0;
  endtask

  task automatic t_reset();
    chk(pwr == 0, "R1 pwr", pwr, 0);
    chk(!busy && !ready && !fault && !ierr, "R1 flags",
        {busy, ready, fault, ierr}, 0);
    chk(cnt == 0, "R1 count", cnt, 0);
  endtask

  task automatic t_sensor1(input int n);
    int t0, dur;
    do_start(1);
    t0 = cyc;
    chk(pwr == 3'b001, "R2 sensor1 power", pwr, 1);
    chk(busy, "R6 busy after start", busy, 1);
    repeat (300) @(negedge clk);
    pulses(n, 2);
    chk(pwr == 3'b001, "R2 power held", pwr, 1);
    wait_ready(t0, dur);
    chk(dur == WIN, "R6 window length", dur, WIN);
    chk(pwr == 0 && !busy, "R6 power off at ready", pwr, 0);
    chk(cnt == CW'(n), "R5 R7 count", cnt, n);
    chk(!fault, "R8 no fault", fault, 0);
    pulses(5, 2);
    repeat (20) @(negedge clk);
    chk(ready && cnt == CW'(n), "R7 result held", cnt, n);
  endtask

  task automatic t_sensor2_ignore();
    int t0, dur;
    do_start(2);
    t0 = cyc;
    chk(cnt == 0 && !ready && !fault, "R4 clear on start", cnt, 0);
    chk(pwr == 3'b010, "R2 sensor2 power", pwr, 2);
    pulses(20, 3);
    do_start(3);
    chk(pwr == 3'b010 && busy, "R10 start ignored", pwr, 2);
    pulses(17, 3);
    wait_ready(t0, dur);
    chk(dur == WIN, "R10 window unchanged", dur, WIN);
    chk(cnt == 37, "R5 count sensor2", cnt, 37);
  endtask

  task automatic t_invalid(input int s);
    do_start(s);
    chk(ierr, "R3 index error", ierr, 1);
    chk(pwr == 0 && !busy && !ready, "R3 nothing powered", pwr, 0);
    repeat (10) @(negedge clk);
    chk(pwr == 0 && !busy && !ready, "R3 stays idle", {busy, ready}, 0);
  endtask

  task automatic t_zero();
    int t0, dur;
    do_start(3);
    t0 = cyc;
    chk(!ierr, "R4 error cleared", ierr, 0);
    chk(pwr == 3'b100, "R2 sensor3 power", pwr, 4);
    wait_ready(t0, dur);
    chk(cnt == 0, "R8 zero count", cnt, 0);
    chk(fault, "R8 fault set", fault, 1);
  endtask

  task automatic t_saturate();
    int t0, dur;
    do_start(1);
    t0 = cyc;
    pulses(8300, 1);
    wait_ready(t0, dur);
    chk(ready, "R9 ready", ready, 1);
    chk(cnt == 8191, "R9 saturate", cnt, 8191);
    chk(!fault, "R9 no fault", fault, 0);
  endtask

  initial begin
    rst_n = 0; start = 0; sel = '0; data = 1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_sensor1(250);
    t_sensor2_ignore();
    t_invalid(0);
    t_invalid(5);
    t_zero();
    t_saturate();
    finish_run();
  end
endmodule